// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block fronts a small shared word memory used by several requester ports. Each port can issue four kinds of access: a plain load, a plain store, a load-linked, and a store-conditional. A load-linked returns the addressed word and records a reservation for that port at that address. A later store-conditional from the same port writes its data only if that reservation is still intact. It then returns 1 on success and 0 on failure, and software retries when it sees 0.

Only one request is accepted per cycle. A fixed-priority arbiter grants the lowest-numbered valid port. A port whose request is not granted may hold it until a later cycle. Atomic exchange, fetch-and-increment and lock acquisition are all built in software from a load-linked followed by a store-conditional. Any write that lands on a reserved address in between breaks the reservation, so the store-conditional fails.

Top module: `resv_mem_monitor`

## Requirements
- R1: After reset no response is flagged, every memory word reads 0, and no port holds a reservation.
- R2: In any cycle with at least one valid request, exactly the lowest-indexed valid port is granted. With no valid request, nothing is granted.
- R3: A granted request is answered exactly one clock later. `rspValid` is then one-hot on the granted port and `rspData` carries the result.
- R4: Load (op 0) and load-linked (op 2) return the word held at the address when the request was granted.
- R5: A plain store (op 1) writes its data and returns 0.
- R6: A store-conditional (op 3) whose port holds a valid reservation for the same address writes its data and returns 1.
- R7: A store-conditional fails, returns 0 and leaves memory unchanged when its port has no valid reservation, or has a reservation for another address.
- R8: A store-conditional always clears its own port's reservation, whether it passes or fails.
- R9: Any successful write to an address clears every reservation on that address, whichever port wrote it and whether the write was a plain store or a store-conditional.
- R10: A new load-linked replaces the port's earlier reservation.
- R11: When two ports present store-conditionals to the same reserved address in one cycle, the lower-indexed port is served first and succeeds. The other port fails when it is served later.
- R12: Exchange and fetch-and-increment sequences built from load-linked and store-conditional give correct results under contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | NUM_PORTS | Request present, one bit per port |
| reqOp | input | NUM_PORTS x 2 | Operation per port: 0 load, 1 store, 2 load-linked, 3 store-conditional |
| reqAddr | input | NUM_PORTS x ADDR_W | Word address per port |
| reqWdata | input | NUM_PORTS x DATA_W | Write data per port |
| grant | output | NUM_PORTS | One-hot: the request accepted this cycle |
| rspValid | output | NUM_PORTS | One-hot: the port being answered this cycle |
| rspData | output | DATA_W | Read word, SC flag (1/0), or 0 for a store |

## Verification
Some properties are checked on every cycle: the grant is a legal choice of the lowest valid port, the response follows its grant by one cycle, stores answer 0, and a store-conditional's result matches the reservation state it met. Every store-conditional is also checked to leave its own reservation cleared. Other behaviour can only be shown by the bench's scenarios: a store from another port breaks a reservation, a new load-linked replaces an old one, two store-conditionals race in one cycle, and contended fetch-and-increment loops reach the right total. Memory contents are checked only through later loads at the ports.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } memOp_e;

  typedef enum logic [1:0] {
    RSP_ZERO = 2'd0,
    RSP_ONE  = 2'd1,
    RSP_READ = 2'd2
  } rspSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrEn;
    rspSel_e rspSel;
  } ctrlStrb_t;

endpackage

// File: rtl/resv_arbiter.sv
module resv_arbiter #(
  parameter int NUM_PORTS = 3,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [NUM_PORTS-1:0] reqValid,
  output logic [NUM_PORTS-1:0] grant,
  output logic [IDX_W-1:0]     grantIdx,
  output logic                 anyGrant
);

  always_comb begin
    grantIdx = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (reqValid[i]) grantIdx = i[IDX_W-1:0];
    end
  end

  assign anyGrant = |reqValid;
  assign grant    = anyGrant ? (NUM_PORTS'(1) << grantIdx) : '0;

endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 4,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              anyGrant,
  input  logic [IDX_W-1:0]                  grantIdx,
  input  logic [1:0]                        gOp,
  input  logic [ADDR_W-1:0]                 gAddr,
  output ctrlStrb_t                         strb,
  output logic [NUM_PORTS-1:0]              resvValid,
  output logic [NUM_PORTS-1:0][ADDR_W-1:0]  resvAddr
);

  memOp_e op;
  logic   scOk;

  assign op   = memOp_e'(gOp);
  assign scOk = anyGrant && (op == OP_SC) && resvValid[grantIdx] &&
                (resvAddr[grantIdx] == gAddr);

  always_comb begin
    strb.wrEn   = anyGrant && ((op == OP_STORE) || scOk);
    strb.rspSel = RSP_ZERO;
    if (anyGrant) begin
      unique case (op)
        OP_LOAD, OP_LL: strb.rspSel = RSP_READ;
        OP_SC:          strb.rspSel = scOk ? RSP_ONE : RSP_ZERO;
        default:        strb.rspSel = RSP_ZERO;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_resv
    logic mine;
    assign mine = anyGrant && (grantIdx == IDX_W'(p));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resvValid[p] <= 1'b0;
        resvAddr[p]  <= '0;
      end else if (mine && op == OP_LL) begin
        resvValid[p] <= 1'b1;
        resvAddr[p]  <= gAddr;
      end else if (mine && op == OP_SC) begin
        resvValid[p] <= 1'b0;
      end else if (strb.wrEn && resvValid[p] && resvAddr[p] == gAddr) begin
        resvValid[p] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [NUM_PORTS-1:0] grant,
  input  logic [ADDR_W-1:0]    gAddr,
  input  logic [DATA_W-1:0]    gWdata,
  output logic [NUM_PORTS-1:0] rspValid,
  output logic [DATA_W-1:0]    rspData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strb.wrEn) begin
      mem[gAddr] <= gWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= '0;
      rspData  <= '0;
    end else begin
      rspValid <= grant;
      unique case (strb.rspSel)
        RSP_READ: rspData <= mem[gAddr];
        RSP_ONE:  rspData <= DATA_W'(1);
        default:  rspData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/resv_mem_monitor.sv
module resv_mem_monitor
  import resv_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_PORTS-1:0]             reqValid,
  input  logic [NUM_PORTS-1:0][1:0]        reqOp,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] reqAddr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] reqWdata,
  output logic [NUM_PORTS-1:0]             grant,
  output logic [NUM_PORTS-1:0]             rspValid,
  output logic [DATA_W-1:0]                rspData
);

  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [IDX_W-1:0]                 grantIdx;
  logic                             anyGrant;
  logic [1:0]                       gOp;
  logic [ADDR_W-1:0]                gAddr;
  logic [DATA_W-1:0]                gWdata;
  ctrlStrb_t                        strb;
  logic [NUM_PORTS-1:0]             resvValid;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] resvAddr;

  assign gOp    = reqOp[grantIdx];
  assign gAddr  = reqAddr[grantIdx];
  assign gWdata = reqWdata[grantIdx];

  resv_arbiter #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .reqValid(reqValid), .grant(grant), .grantIdx(grantIdx), .anyGrant(anyGrant)
  );

  resv_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .anyGrant(anyGrant), .grantIdx(grantIdx),
    .gOp(gOp), .gAddr(gAddr), .strb(strb),
    .resvValid(resvValid), .resvAddr(resvAddr)
  );

  resv_datapath #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .grant(grant),
    .gAddr(gAddr), .gWdata(gWdata), .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: rtl/resv_checker.sv
module resv_checker #(
  parameter int NUM_PORTS = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input logic                             clk,
  input logic                             rstN,
  input logic [NUM_PORTS-1:0]             reqValid,
  input logic [NUM_PORTS-1:0][1:0]        reqOp,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] reqAddr,
  input logic [NUM_PORTS-1:0]             grant,
  input logic [NUM_PORTS-1:0]             rspValid,
  input logic [DATA_W-1:0]                rspData,
  input logic [NUM_PORTS-1:0]             resvValid,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] resvAddr
);

  logic [IDX_W-1:0]  cIdx;
  logic [1:0]        cOp;
  logic [ADDR_W-1:0] cAddr;
  logic              scSeen, resHit;

  always_comb begin
    cIdx = '0;
    for (int i = 0; i < NUM_PORTS; i++) if (grant[i]) cIdx = i[IDX_W-1:0];
  end
  assign cOp    = reqOp[cIdx];
  assign cAddr  = reqAddr[cIdx];
  assign scSeen = (grant != '0) && (cOp == 2'd3);
  assign resHit = resvValid[cIdx] && (resvAddr[cIdx] == cAddr);

  // R2
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((grant & ~reqValid) == '0) && $onehot0(grant));

  // R2
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid != '0) |-> (grant != '0) && ((reqValid & (grant - 1'b1)) == '0));

  // R3
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0) |=> (rspValid == $past(grant)));

  // R3
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grant == '0) |=> (rspValid == '0));

  // R5
  store_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((grant != '0) && cOp == 2'd1) |=> (rspData == '0));

  // R6
  sc_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (scSeen && resHit) |=> (rspData == DATA_W'(1)));

  // R7
  sc_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (scSeen && !resHit) |=> (rspData == '0));

  // R8
  sc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    scSeen |=> !resvValid[$past(cIdx)]);

endmodule

bind resv_mem_monitor resv_checker #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_resv_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
  .grant(grant), .rspValid(rspValid), .rspData(rspData),
  .resvValid(resvValid), .resvAddr(resvAddr)
);

// File: tb/resv_mem_monitor_bench.sv
`timescale 1ns/1ps
module resv_mem_monitor_bench;

  localparam int NP = 3;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LL = 2'd2, SC = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0]         reqValid = '0;
  logic [NP-1:0][1:0]    reqOp = '0;
  logic [NP-1:0][AW-1:0] reqAddr = '0;
  logic [NP-1:0][DW-1:0] reqWdata = '0;
  logic [NP-1:0]         grant, rspValid;
  logic [DW-1:0]         rspData;

  resv_mem_monitor #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) u_resv_mem_monitor (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .grant(grant), .rspValid(rspValid), .rspData(rspData)
  );

  int nChecks = 0, nFails = 0;
  string tag = "R1";
  string pendTag = "R1";

  // staged stimulus for the next cycle
  logic [NP-1:0]         nV = '0;
  logic [NP-1:0][1:0]    nOp = '0;
  logic [NP-1:0][AW-1:0] nAddr = '0;
  logic [NP-1:0][DW-1:0] nData = '0;

  // reference model
  logic [DW-1:0] mMem [DEPTH];
  logic          mResV [NP];
  logic [AW-1:0] mResA [NP];
  logic          pendV = 1'b0;
  int            pendPort = 0;
  logic [DW-1:0] pendData = '0;
  int            lastPort = -1;
  logic [DW-1:0] lastRsp = '0;

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  function automatic int lowestPort(logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [DW-1:0] modelApply(int p, logic [1:0] op, logic [AW-1:0] a,
                                               logic [DW-1:0] d);
    logic ok;
    case (op)
      LD: return mMem[a];
      LL: begin mResV[p] = 1'b1; mResA[p] = a; return mMem[a]; end
      ST: begin
        mMem[a] = d;
        for (int i = 0; i < NP; i++) if (mResV[i] && mResA[i] == a) mResV[i] = 1'b0;
        return '0;
      end
      default: begin
        ok = mResV[p] && (mResA[p] == a);
        mResV[p] = 1'b0;
        if (ok) begin
          mMem[a] = d;
          for (int i = 0; i < NP; i++) if (mResV[i] && mResA[i] == a) mResV[i] = 1'b0;
          return DW'(1);
        end
        return '0;
      end
    endcase
  endfunction

  task automatic step();
    int p;
    @(negedge clk);
    if (pendV) begin
      check({pendTag, " R3 rspValid"}, 32'(rspValid), 32'(NP'(1) << pendPort));
      check({pendTag, " rspData"}, 32'(rspData), 32'(pendData));
    end else begin
      check({pendTag, " R3 idle rspValid"}, 32'(rspValid), 32'd0);
    end
    reqValid = nV; reqOp = nOp; reqAddr = nAddr; reqWdata = nData;
    #1;
    p = lowestPort(nV);
    check({tag, " R2 grant"}, 32'(grant), (p < 0) ? 32'd0 : 32'(NP'(1) << p));
    pendTag = tag;
    if (p >= 0) begin
      pendV = 1'b1; pendPort = p;
      pendData = modelApply(p, nOp[p], nAddr[p], nData[p]);
      lastPort = p; lastRsp = pendData;
    end else begin
      pendV = 1'b0; lastPort = -1;
    end
  endtask

  task automatic one(int p, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                     output logic [DW-1:0] r);
    nV = '0; nV[p] = 1'b1; nOp[p] = op; nAddr[p] = a; nData[p] = d;
    step();
    nV = '0;
    step();
    r = rspData;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [DW-1:0] r;
    int unsigned seedDummy;
    int phase [NP];
    int done [NP];
    logic [DW-1:0] got [NP];
    int guard;
    seedDummy = $urandom(32'd2024);
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    for (int i = 0; i < NP; i++) begin mResV[i] = 1'b0; mResA[i] = '0; end

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rspValid after reset", 32'(rspValid), 32'd0);
    rstN = 1'b1;

    tag = "R1";
    one(0, SC, 4'd3, 16'hAAAA, r); check("R1 SC with no reservation", 32'(r), 32'd0);
    one(2, LD, 4'd5, 16'h0, r);   check("R1 memory zero", 32'(r), 32'd0);
    one(0, LD, 4'd3, 16'h0, r);   check("R1 failed SC left zero", 32'(r), 32'd0);

    tag = "R5";
    one(1, ST, 4'd2, 16'h1234, r); check("R5 store rsp", 32'(r), 32'd0);
    tag = "R4";
    one(0, LD, 4'd2, 16'h0, r);    check("R4 load", 32'(r), 32'h1234);

    tag = "R6";
    one(0, LL, 4'd2, 16'h0, r);    check("R6/R4 LL value", 32'(r), 32'h1234);
    one(0, SC, 4'd2, 16'h0055, r); check("R6 SC pass", 32'(r), 32'd1);
    one(1, LD, 4'd2, 16'h0, r);    check("R6 written", 32'(r), 32'h0055);

    tag = "R8";
    one(0, SC, 4'd2, 16'h0066, r); check("R8 second SC fails", 32'(r), 32'd0);
    one(1, LD, 4'd2, 16'h0, r);    check("R8 memory kept", 32'(r), 32'h0055);
    one(2, LL, 4'd11, 16'h0, r);
    one(2, SC, 4'd12, 16'h0077, r); check("R7 wrong addr SC", 32'(r), 32'd0);
    one(2, SC, 4'd11, 16'h0077, r); check("R8 cleared by failed SC", 32'(r), 32'd0);

    tag = "R7";
    one(1, LL, 4'd4, 16'h0, r);
    one(1, SC, 4'd5, 16'h0099, r); check("R7 other addr fails", 32'(r), 32'd0);
    one(0, LD, 4'd5, 16'h0, r);    check("R7 no write", 32'(r), 32'd0);

    tag = "R9";
    one(2, LL, 4'd6, 16'h0, r);
    one(1, LL, 4'd6, 16'h0, r);
    one(0, ST, 4'd6, 16'h0007, r);
    one(2, SC, 4'd6, 16'h0009, r); check("R9 store broke port2", 32'(r), 32'd0);
    one(1, SC, 4'd6, 16'h0009, r); check("R9 store broke port1", 32'(r), 32'd0);
    one(0, LD, 4'd6, 16'h0, r);    check("R9 value", 32'(r), 32'h0007);
    one(0, LL, 4'd7, 16'h0, r);
    one(1, LL, 4'd7, 16'h0, r);
    one(1, SC, 4'd7, 16'h0003, r); check("R9 SC pass", 32'(r), 32'd1);
    one(0, SC, 4'd7, 16'h0004, r); check("R9 SC broke other", 32'(r), 32'd0);

    tag = "R10";
    one(2, LL, 4'd8, 16'h0, r);
    one(2, LL, 4'd9, 16'h0, r);
    one(2, SC, 4'd8, 16'h0001, r); check("R10 old reservation gone", 32'(r), 32'd0);
    one(2, LL, 4'd8, 16'h0, r);
    one(2, LL, 4'd9, 16'h0, r);
    one(2, SC, 4'd9, 16'h0002, r); check("R10 new reservation", 32'(r), 32'd1);

    tag = "R11";
    one(0, LL, 4'd1, 16'h0, r);
    one(1, LL, 4'd1, 16'h0, r);
    nV = 3'b011; nOp[0] = SC; nOp[1] = SC; nAddr[0] = 4'd1; nAddr[1] = 4'd1;
    nData[0] = 16'h00A0; nData[1] = 16'h00B0;
    step();
    check("R11 low port granted", 32'(grant), 32'd1);
    nV = 3'b010;
    step();
    check("R11 high port next", 32'(grant), 32'd2);
    check("R11 low port SC wins", 32'(rspData), 32'd1);
    nV = '0;
    step();
    check("R11 high port SC fails", 32'(rspData), 32'd0);
    one(2, LD, 4'd1, 16'h0, r);    check("R11 winner data", 32'(r), 32'h00A0);

    tag = "R12";
    one(0, ST, 4'd10, 16'h0011, r);
    one(1, LL, 4'd10, 16'h0, r);   check("R12 exchange old", 32'(r), 32'h0011);
    one(1, SC, 4'd10, 16'h0022, r); check("R12 exchange SC", 32'(r), 32'd1);
    one(2, LD, 4'd10, 16'h0, r);   check("R12 exchange new", 32'(r), 32'h0022);

    // random mix, checked against the model every cycle
    tag = "R2 R4 R6 R7 R9 random";
    for (int c = 0; c < 800; c++) begin
      for (int p = 0; p < NP; p++) begin
        nV[p] = ($urandom % 3) != 0;
        nOp[p] = 2'($urandom % 4);
        nAddr[p] = AW'($urandom % 4);
        nData[p] = DW'($urandom);
      end
      step();
    end
    nV = '0;
    step();

    // contended fetch-and-increment on word 12
    tag = "R12 fetch-inc";
    one(0, ST, 4'd12, 16'h0, r);
    for (int p = 0; p < NP; p++) begin phase[p] = 0; done[p] = 0; got[p] = '0; end
    guard = 0;
    while ((done[0] < 4 || done[1] < 4 || done[2] < 4) && guard < 5000) begin
      for (int p = 0; p < NP; p++) begin
        nV[p] = (done[p] < 4) && (($urandom % 3) != 0);
        nOp[p] = (phase[p] == 0) ? LL : SC;
        nAddr[p] = 4'd12;
        nData[p] = got[p] + 1'b1;
      end
      step();
      if (lastPort >= 0) begin
        if (phase[lastPort] == 0) begin
          got[lastPort] = lastRsp; phase[lastPort] = 1;
        end else begin
          if (lastRsp == DW'(1)) done[lastPort]++;
          phase[lastPort] = 0;
        end
      end
      guard++;
    end
    nV = '0;
    step();
    one(1, LD, 4'd12, 16'h0, r);
    check("R12 fetch-inc total", 32'(r), 32'd12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule